// File: doc/BRIEF.md
# Shared Overflow Miss Status File

This block is the second, larger tier of a miss handling structure that sits beside a banked first-level data cache. Each cache bank has its own small file of outstanding misses. When that small file runs out of room, the bank pushes a whole entry into this shared file: the line address together with all of the subentries it has collected. A bank's filter may report that a line is possibly held here. The bank then sends a lookup that carries a new secondary-miss subentry. On a hit the subentry is appended. On a miss the lookup comes back as not found, and the bank treats the request as a primary miss.

The file is fully associative and unpipelined. Only one operation is in flight at any time, and each operation takes two cycles: a grant cycle and an execute cycle. Line fills win over all bank traffic. The banks share the file by round-robin arbitration. A fill that finds its line returns the collected subentries, frees the entry and broadcasts a remove pulse with the line address so that every bank can clear its filter. When every entry is occupied, a full flag goes to all banks. Displacements are then held back, while lookups keep flowing.

A requester raises its valid and keeps its request fields steady until it sees its grant pulse. It lowers the valid on the next clock edge.

Top module: `shared_miss_file`

## Requirements
- R1: After reset no entry is held, `full_o` is low on every bank, and all grant, done and remove outputs are zero.
- R2: An idle file samples its requests on a clock edge. A pending fill is taken before any bank request. Among eligible banks the choice is round-robin, starting at the bank after the last bank granted. Inside one bank a displacement goes ahead of a lookup unless the file is full.
- R3: Every operation takes two cycles. Its grant pulse appears for one cycle after the sampling edge, and the lookup or fill result appears in the cycle after that. No grant appears in the cycle right after a grant.
- R4: A displacement stores the line address, a subentry count from 1 to NUM_SUBS, and the first `count` subentries. A later fill that hits returns the count on `fill_num_o` and the subentries in arrival order on `fill_subs_o`, subentry j in slice j. Unused slices are zero.
- R5: A lookup that hits an entry holding fewer than NUM_SUBS subentries appends its payload as the next subentry and reports status 1 (appended).
- R6: A lookup that hits an entry already holding NUM_SUBS subentries reports status 2 (no room) and leaves the entry unchanged.
- R7: A lookup whose line is not held reports status 0 (not found) and changes nothing.
- R8: `full_o` is high on every bank exactly when all NUM_ENTRIES entries are in use. While it is high, no displacement is granted, but lookups are still served. A held displacement is granted once a fill frees an entry.
- R9: A fill that hits frees the entry and pulses `fill_done_o` with `fill_hit_o` = 1. In the same cycle it pulses `rm_valid_o` on every bank, with the line on `rm_addr_o`.
- R10: A fill that misses pulses `fill_done_o` with `fill_hit_o` = 0 and a zero count. It raises no remove pulse and leaves the contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | NUM_BANKS | Per-bank displacement request |
| disp_addr_i | input | NUM_BANKS x ADDR_W | Line address of the displaced entry |
| disp_num_i | input | NUM_BANKS x CNT_W | Subentry count of the displaced entry |
| disp_subs_i | input | NUM_BANKS x NUM_SUBS x SUB_W | Subentries of the displaced entry |
| disp_gnt_o | output | NUM_BANKS | Displacement accepted pulse |
| lk_valid_i | input | NUM_BANKS | Per-bank lookup/append request |
| lk_addr_i | input | NUM_BANKS x ADDR_W | Line address looked up |
| lk_sub_i | input | NUM_BANKS x SUB_W | Subentry to append on a hit |
| lk_gnt_o | output | NUM_BANKS | Lookup accepted pulse |
| lk_done_o | output | NUM_BANKS | Lookup result pulse |
| lk_status_o | output | 2 | Result of the last lookup: 0 not found, 1 appended, 2 no room |
| fill_valid_i | input | 1 | Line fill arrived |
| fill_addr_i | input | ADDR_W | Line address of the fill |
| fill_gnt_o | output | 1 | Fill accepted pulse |
| fill_done_o | output | 1 | Fill result pulse |
| fill_hit_o | output | 1 | Last fill found its entry |
| fill_num_o | output | CNT_W | Subentry count returned by the last fill |
| fill_subs_o | output | NUM_SUBS x SUB_W | Subentries returned by the last fill |
| rm_valid_o | output | NUM_BANKS | Filter remove pulse to each bank |
| rm_addr_o | output | ADDR_W | Line address to remove |
| full_o | output | NUM_BANKS | All entries in use |

## Verification
Two things can land on the same sampling edge. One is a fill arriving while many banks hold requests. The other is a displacement and a lookup raised together, either from one bank or while the file is full. The bench provokes the first by raising a fill together with a lookup from every bank. It provokes the second by pairing a displacement and a lookup in one bank, and later by filling the file and then raising a displacement beside another bank's lookup. A behavioural model with its own tables predicts every grant, result and remove pulse each cycle and compares them. Directed checks then confirm the grant order, that the held displacement stays pending, and the returned subentries.

// File: rtl/smf_pkg.sv
package smf_pkg;
  typedef enum logic [1:0] {
    LK_NOTFOUND = 2'd0,
    LK_APPENDED = 2'd1,
    LK_NOROOM   = 2'd2
  } lk_status_e;

  typedef enum logic [1:0] {
    OP_FILL = 2'd0,
    OP_DISP = 2'd1,
    OP_LOOK = 2'd2
  } op_e;
endpackage

// File: rtl/smf_rr_arb.sv
module smf_rr_arb #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          adv_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] ptr_q;

  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < int'(N); i++) begin
      automatic int c = int'(ptr_q) + i;
      if (c >= int'(N)) c = c - int'(N);
      if (!any_o && req_i[c]) begin
        any_o = 1'b1;
        idx_o = IW'(c);
      end
    end
  end

  // pointer moves past the bank just served
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (adv_i && any_o) ptr_q <= (int'(idx_o) == int'(N) - 1) ? '0 : idx_o + 1'b1;
  end
endmodule

// File: rtl/smf_store.sv
module smf_store #(
  parameter int unsigned E      = 32,
  parameter int unsigned S      = 16,
  parameter int unsigned A      = 26,
  parameter int unsigned W      = 12,
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned IW     = 5,
  parameter int unsigned UW     = 6,
  parameter int unsigned SLOT_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [A-1:0]        key_i,
  input  logic                alloc_i,
  input  logic [CNT_W-1:0]    alloc_num_i,
  input  logic [S-1:0][W-1:0] alloc_subs_i,
  input  logic                append_i,
  input  logic [W-1:0]        append_sub_i,
  input  logic                free_i,
  output logic                hit_o,
  output logic [CNT_W-1:0]    hit_num_o,
  output logic [S-1:0][W-1:0] hit_subs_o,
  output logic [UW-1:0]       used_o
);
  logic                vld [E];
  logic [A-1:0]        tag [E];
  logic [CNT_W-1:0]    cnt [E];
  logic [S-1:0][W-1:0] sub [E];
  logic [IW-1:0]       hit_idx, free_idx;
  logic                free_found;
  logic [S-1:0][W-1:0] masked;

  always_comb begin
    hit_o = 1'b0;
    hit_idx = '0;
    free_found = 1'b0;
    free_idx = '0;
    used_o = '0;
    for (int e = 0; e < int'(E); e++) begin
      if (!hit_o && vld[e] && tag[e] == key_i) begin
        hit_o = 1'b1;
        hit_idx = IW'(e);
      end
      if (!free_found && !vld[e]) begin
        free_found = 1'b1;
        free_idx = IW'(e);
      end
      used_o = used_o + UW'(vld[e]);
    end
  end

  assign hit_num_o  = cnt[hit_idx];
  assign hit_subs_o = sub[hit_idx];

  // slots above the displaced count are zeroed on entry
  for (genvar j = 0; j < S; j++) begin : g_mask
    assign masked[j] = (CNT_W'(j) < alloc_num_i) ? alloc_subs_i[j] : '0;
  end

  for (genvar e = 0; e < E; e++) begin : g_ent
    logic                v_q;
    logic [A-1:0]        t_q;
    logic [CNT_W-1:0]    c_q;
    logic [S-1:0][W-1:0] s_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        t_q <= '0;
        c_q <= '0;
        s_q <= '0;
      end else if (alloc_i && free_found && free_idx == IW'(e)) begin
        v_q <= 1'b1;
        t_q <= key_i;
        c_q <= alloc_num_i;
        s_q <= masked;
      end else if (hit_o && hit_idx == IW'(e)) begin
        if (free_i) v_q <= 1'b0;
        else if (append_i) begin
          c_q <= c_q + 1'b1;
          s_q[c_q[SLOT_W-1:0]] <= append_sub_i;
        end
      end
    end

    assign vld[e] = v_q;
    assign tag[e] = t_q;
    assign cnt[e] = c_q;
    assign sub[e] = s_q;
  end
endmodule

// File: rtl/shared_miss_file.sv
module shared_miss_file
  import smf_pkg::*;
#(
  parameter int unsigned NUM_BANKS   = 8,
  parameter int unsigned NUM_ENTRIES = 32,
  parameter int unsigned NUM_SUBS    = 16,
  parameter int unsigned ADDR_W      = 26,
  parameter int unsigned SUB_W       = 12,
  localparam int unsigned CNT_W      = $clog2(NUM_SUBS + 1)
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic [NUM_BANKS-1:0]                  disp_valid_i,
  input  logic [NUM_BANKS-1:0][ADDR_W-1:0]      disp_addr_i,
  input  logic [NUM_BANKS-1:0][CNT_W-1:0]       disp_num_i,
  input  logic [NUM_BANKS-1:0][NUM_SUBS-1:0][SUB_W-1:0] disp_subs_i,
  output logic [NUM_BANKS-1:0]                  disp_gnt_o,
  input  logic [NUM_BANKS-1:0]                  lk_valid_i,
  input  logic [NUM_BANKS-1:0][ADDR_W-1:0]      lk_addr_i,
  input  logic [NUM_BANKS-1:0][SUB_W-1:0]       lk_sub_i,
  output logic [NUM_BANKS-1:0]                  lk_gnt_o,
  output logic [NUM_BANKS-1:0]                  lk_done_o,
  output logic [1:0]                            lk_status_o,
  input  logic                                  fill_valid_i,
  input  logic [ADDR_W-1:0]                     fill_addr_i,
  output logic                                  fill_gnt_o,
  output logic                                  fill_done_o,
  output logic                                  fill_hit_o,
  output logic [CNT_W-1:0]                      fill_num_o,
  output logic [NUM_SUBS-1:0][SUB_W-1:0]        fill_subs_o,
  output logic [NUM_BANKS-1:0]                  rm_valid_o,
  output logic [ADDR_W-1:0]                     rm_addr_o,
  output logic [NUM_BANKS-1:0]                  full_o
);
  localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int unsigned IDX_W  = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam int unsigned USED_W = $clog2(NUM_ENTRIES + 1);
  localparam int unsigned SLOT_W = (NUM_SUBS > 1) ? $clog2(NUM_SUBS) : 1;

  logic                           busy_q;
  op_e                            op_q;
  logic [BANK_W-1:0]              bank_q;
  logic [ADDR_W-1:0]              addr_q;
  logic [SUB_W-1:0]               sub_q;
  logic [CNT_W-1:0]               num_q;
  logic [NUM_SUBS-1:0][SUB_W-1:0] subs_q;
  logic                           rm_q;

  logic [NUM_BANKS-1:0]           elig;
  logic                           any_req;
  logic [BANK_W-1:0]              win;
  logic                           full;
  logic [USED_W-1:0]              used;
  logic                           hit;
  logic [CNT_W-1:0]               hit_num;
  logic [NUM_SUBS-1:0][SUB_W-1:0] hit_subs;
  logic                           room, do_alloc, do_append, do_free;

  assign full       = (used == USED_W'(NUM_ENTRIES));
  assign full_o     = {NUM_BANKS{full}};
  assign rm_valid_o = {NUM_BANKS{rm_q}};
  assign elig       = (disp_valid_i & {NUM_BANKS{~full}}) | lk_valid_i;

  smf_rr_arb #(.N(NUM_BANKS), .IW(BANK_W)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (elig),
    .adv_i  (~busy_q & ~fill_valid_i),
    .any_o  (any_req),
    .idx_o  (win)
  );

  assign room      = hit_num < CNT_W'(NUM_SUBS);
  assign do_alloc  = busy_q && op_q == OP_DISP;
  assign do_append = busy_q && op_q == OP_LOOK && hit && room;
  assign do_free   = busy_q && op_q == OP_FILL && hit;

  smf_store #(
    .E(NUM_ENTRIES), .S(NUM_SUBS), .A(ADDR_W), .W(SUB_W),
    .CNT_W(CNT_W), .IW(IDX_W), .UW(USED_W), .SLOT_W(SLOT_W)
  ) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .key_i        (addr_q),
    .alloc_i      (do_alloc),
    .alloc_num_i  (num_q),
    .alloc_subs_i (subs_q),
    .append_i     (do_append),
    .append_sub_i (sub_q),
    .free_i       (do_free),
    .hit_o        (hit),
    .hit_num_o    (hit_num),
    .hit_subs_o   (hit_subs),
    .used_o       (used)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      op_q        <= OP_FILL;
      bank_q      <= '0;
      addr_q      <= '0;
      sub_q       <= '0;
      num_q       <= '0;
      subs_q      <= '0;
      disp_gnt_o  <= '0;
      lk_gnt_o    <= '0;
      fill_gnt_o  <= 1'b0;
      lk_done_o   <= '0;
      lk_status_o <= LK_NOTFOUND;
      fill_done_o <= 1'b0;
      fill_hit_o  <= 1'b0;
      fill_num_o  <= '0;
      fill_subs_o <= '0;
      rm_q        <= 1'b0;
      rm_addr_o   <= '0;
    end else begin
      disp_gnt_o  <= '0;
      lk_gnt_o    <= '0;
      fill_gnt_o  <= 1'b0;
      lk_done_o   <= '0;
      fill_done_o <= 1'b0;
      rm_q        <= 1'b0;
      if (!busy_q) begin
        // grant phase: fill first, then the round-robin winner
        if (fill_valid_i) begin
          busy_q     <= 1'b1;
          op_q       <= OP_FILL;
          addr_q     <= fill_addr_i;
          fill_gnt_o <= 1'b1;
        end else if (any_req) begin
          busy_q <= 1'b1;
          bank_q <= win;
          if (disp_valid_i[win] && !full) begin
            op_q            <= OP_DISP;
            addr_q          <= disp_addr_i[win];
            num_q           <= disp_num_i[win];
            subs_q          <= disp_subs_i[win];
            disp_gnt_o[win] <= 1'b1;
          end else begin
            op_q          <= OP_LOOK;
            addr_q        <= lk_addr_i[win];
            sub_q         <= lk_sub_i[win];
            lk_gnt_o[win] <= 1'b1;
          end
        end
      end else begin
        // execute phase
        busy_q <= 1'b0;
        case (op_q)
          OP_LOOK: begin
            lk_done_o[bank_q] <= 1'b1;
            lk_status_o <= !hit ? LK_NOTFOUND : (room ? LK_APPENDED : LK_NOROOM);
          end
          OP_FILL: begin
            fill_done_o <= 1'b1;
            fill_hit_o  <= hit;
            fill_num_o  <= hit ? hit_num : '0;
            fill_subs_o <= hit ? hit_subs : '0;
            if (hit) begin
              rm_q      <= 1'b1;
              rm_addr_o <= addr_q;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smf_checker.sv
module smf_checker #(
  parameter int unsigned NUM_BANKS = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 fill_valid_i,
  input logic [NUM_BANKS-1:0] disp_gnt_o,
  input logic [NUM_BANKS-1:0] lk_gnt_o,
  input logic                 fill_gnt_o,
  input logic [NUM_BANKS-1:0] lk_done_o,
  input logic                 fill_done_o,
  input logic                 fill_hit_o,
  input logic [NUM_BANKS-1:0] rm_valid_o,
  input logic [NUM_BANKS-1:0] full_o
);
  logic any_gnt;
  assign any_gnt = (|disp_gnt_o) || (|lk_gnt_o) || fill_gnt_o;

  a_r3_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({disp_gnt_o, lk_gnt_o, fill_gnt_o}));

  a_r3_no_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_gnt |=> !any_gnt);

  a_r3_lookup_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|lk_gnt_o) |=> (lk_done_o == $past(lk_gnt_o)));

  a_r3_fill_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_gnt_o |=> fill_done_o);

  a_r2_fill_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|disp_gnt_o) || (|lk_gnt_o)) |-> !$past(fill_valid_i));

  a_r8_no_disp_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|disp_gnt_o) |-> !$past(|full_o));

  a_r9_remove_with_fill_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(rm_valid_o) != 0) |-> (fill_done_o && fill_hit_o));
endmodule

bind shared_miss_file smf_checker #(.NUM_BANKS(NUM_BANKS)) u_smf_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fill_valid_i (fill_valid_i),
  .disp_gnt_o   (disp_gnt_o),
  .lk_gnt_o     (lk_gnt_o),
  .fill_gnt_o   (fill_gnt_o),
  .lk_done_o    (lk_done_o),
  .fill_done_o  (fill_done_o),
  .fill_hit_o   (fill_hit_o),
  .rm_valid_o   (rm_valid_o),
  .full_o       (full_o)
);

// File: tb/shared_miss_file_bench.sv
module shared_miss_file_bench;
  localparam int B  = 8;
  localparam int E  = 32;
  localparam int S  = 16;
  localparam int A  = 26;
  localparam int W  = 12;
  localparam int CW = 5;

  typedef logic [W-1:0] sq_t[$];

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk_i = ~clk_i;

  logic [B-1:0]              disp_valid = '0;
  logic [B-1:0][A-1:0]       disp_addr  = '0;
  logic [B-1:0][CW-1:0]      disp_num   = '0;
  logic [B-1:0][S-1:0][W-1:0] disp_subs = '0;
  logic [B-1:0]              lk_valid   = '0;
  logic [B-1:0][A-1:0]       lk_addr    = '0;
  logic [B-1:0][W-1:0]       lk_sub     = '0;
  logic                      fill_valid = 1'b0;
  logic [A-1:0]              fill_addr  = '0;

  logic [B-1:0]       disp_gnt_o, lk_gnt_o, lk_done_o, rm_valid_o, full_o;
  logic [1:0]         lk_status_o;
  logic               fill_gnt_o, fill_done_o, fill_hit_o;
  logic [CW-1:0]      fill_num_o;
  logic [S-1:0][W-1:0] fill_subs_o;
  logic [A-1:0]       rm_addr_o;

  shared_miss_file #(.NUM_BANKS(B), .NUM_ENTRIES(E), .NUM_SUBS(S), .ADDR_W(A), .SUB_W(W))
  u_shared_miss_file (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .disp_valid_i(disp_valid), .disp_addr_i(disp_addr), .disp_num_i(disp_num),
    .disp_subs_i(disp_subs), .disp_gnt_o(disp_gnt_o),
    .lk_valid_i(lk_valid), .lk_addr_i(lk_addr), .lk_sub_i(lk_sub),
    .lk_gnt_o(lk_gnt_o), .lk_done_o(lk_done_o), .lk_status_o(lk_status_o),
    .fill_valid_i(fill_valid), .fill_addr_i(fill_addr), .fill_gnt_o(fill_gnt_o),
    .fill_done_o(fill_done_o), .fill_hit_o(fill_hit_o), .fill_num_o(fill_num_o),
    .fill_subs_o(fill_subs_o), .rm_valid_o(rm_valid_o), .rm_addr_o(rm_addr_o),
    .full_o(full_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // behavioural model state
  sq_t           m_tab [logic [A-1:0]];
  bit            m_busy = 0;
  int            m_kind = 0;  // 0 fill, 1 displace, 2 lookup
  int            m_bank = 0;
  int            m_ptr  = 0;
  logic [A-1:0]  m_addr;
  logic [W-1:0]  m_sub;
  int            m_num;
  logic [S-1:0][W-1:0] m_subs;

  logic [B-1:0]  e_disp_gnt = '0, e_lk_gnt = '0, e_lk_done = '0;
  logic          e_fill_gnt = 0, e_fill_done = 0, e_fill_hit = 0, e_rm = 0, e_full = 0;
  logic [1:0]    e_status = '0;
  logic [CW-1:0] e_fill_num = '0;
  logic [S-1:0][W-1:0] e_fill_subs = '0;
  logic [A-1:0]  e_rm_addr = '0;

  // observations from the ports
  int            gnt_log[$];
  logic [1:0]    last_status;
  bit            last_fill_hit;
  int            last_fill_num;
  logic [S-1:0][W-1:0] last_fill_subs;
  int            rm_cnt = 0;
  logic [A-1:0]  last_rm;

  function automatic void chk(bit ok, string tag, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endfunction

  function automatic logic [W-1:0] subval(logic [A-1:0] a, int j);
    return W'(a) + W'(j * 7) + 12'h101;
  endfunction

  task automatic model_step();
    e_disp_gnt = '0; e_lk_gnt = '0; e_fill_gnt = 0;
    e_lk_done = '0; e_fill_done = 0; e_rm = 0;
    if (!m_busy) begin
      if (fill_valid) begin
        m_busy = 1; m_kind = 0; m_addr = fill_addr; e_fill_gnt = 1;
      end else begin
        for (int i = 0; i < B; i++) begin
          automatic int b = (m_ptr + i) % B;
          automatic bit dok = disp_valid[b] && (m_tab.num() < E);
          if (!m_busy && (dok || lk_valid[b])) begin
            m_busy = 1; m_bank = b; m_ptr = (b + 1) % B;
            if (dok) begin
              m_kind = 1; m_addr = disp_addr[b]; m_num = int'(disp_num[b]);
              m_subs = disp_subs[b]; e_disp_gnt[b] = 1;
            end else begin
              m_kind = 2; m_addr = lk_addr[b]; m_sub = lk_sub[b]; e_lk_gnt[b] = 1;
            end
          end
        end
      end
    end else begin
      m_busy = 0;
      if (m_kind == 1) begin
        automatic sq_t q = {};
        for (int j = 0; j < m_num; j++) q.push_back(m_subs[j]);
        m_tab[m_addr] = q;
      end else if (m_kind == 2) begin
        e_lk_done[m_bank] = 1;
        if (!m_tab.exists(m_addr)) e_status = 2'd0;
        else if (m_tab[m_addr].size() < S) begin
          automatic sq_t q = m_tab[m_addr];
          q.push_back(m_sub);
          m_tab[m_addr] = q;
          e_status = 2'd1;
        end else e_status = 2'd2;
      end else begin
        e_fill_done = 1;
        e_fill_subs = '0;
        if (m_tab.exists(m_addr)) begin
          automatic sq_t q = m_tab[m_addr];
          e_fill_hit = 1; e_fill_num = CW'(q.size());
          foreach (q[j]) e_fill_subs[j] = q[j];
          m_tab.delete(m_addr);
          e_rm = 1; e_rm_addr = m_addr;
        end else begin
          e_fill_hit = 0; e_fill_num = '0;
        end
      end
    end
    e_full = (m_tab.num() == E);
  endtask

  task automatic compare();
    chk(disp_gnt_o === e_disp_gnt, "R2 displacement grant", disp_gnt_o, e_disp_gnt);
    chk(lk_gnt_o === e_lk_gnt, "R2 lookup grant", lk_gnt_o, e_lk_gnt);
    chk(fill_gnt_o === e_fill_gnt, "R3 fill grant", fill_gnt_o, e_fill_gnt);
    chk(lk_done_o === e_lk_done, "R3 lookup done", lk_done_o, e_lk_done);
    chk(lk_status_o === e_status, "R5 lookup status", lk_status_o, e_status);
    chk({fill_done_o, fill_hit_o, fill_num_o} === {e_fill_done, e_fill_hit, e_fill_num},
        "R10 fill result", {fill_done_o, fill_hit_o, fill_num_o}, {e_fill_done, e_fill_hit, e_fill_num});
    chk(fill_subs_o === e_fill_subs, "R4 fill subentries", fill_subs_o, e_fill_subs);
    chk(rm_valid_o === {B{e_rm}}, "R9 remove pulse", rm_valid_o, {B{e_rm}});
    chk(rm_addr_o === e_rm_addr, "R9 remove address", rm_addr_o, e_rm_addr);
    chk(full_o === {B{e_full}}, "R8 full", full_o, {B{e_full}});
  endtask

  task automatic tick();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    compare();
    if (|lk_done_o) last_status = lk_status_o;
    if (fill_done_o) begin
      last_fill_hit = fill_hit_o; last_fill_num = int'(fill_num_o); last_fill_subs = fill_subs_o;
    end
    if (rm_valid_o[0]) begin rm_cnt++; last_rm = rm_addr_o; end
    if (fill_gnt_o) gnt_log.push_back(100);
    for (int b = 0; b < B; b++) begin
      if (disp_gnt_o[b]) gnt_log.push_back(b);
      if (lk_gnt_o[b]) gnt_log.push_back(50 + b);
    end
    disp_valid = disp_valid & ~e_disp_gnt;
    lk_valid   = lk_valid & ~e_lk_gnt;
    if (e_fill_gnt) fill_valid = 0;
  endtask

  task automatic disp(int b, logic [A-1:0] a, int n);
    disp_valid[b] = 1; disp_addr[b] = a; disp_num[b] = CW'(n);
    for (int j = 0; j < S; j++) disp_subs[b][j] = (j < n) ? subval(a, j) : W'($urandom);
  endtask

  task automatic look(int b, logic [A-1:0] a, logic [W-1:0] s);
    lk_valid[b] = 1; lk_addr[b] = a; lk_sub[b] = s;
  endtask

  task automatic fill(logic [A-1:0] a);
    fill_valid = 1; fill_addr = a;
  endtask

  task automatic drain();
    while ((|disp_valid) || (|lk_valid) || fill_valid) tick();
    tick(); tick();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    tick();
    // R1 reset state
    chk(full_o === '0 && disp_gnt_o === '0 && lk_done_o === '0 && rm_valid_o === '0,
        "R1 reset state", {full_o, disp_gnt_o, lk_done_o, rm_valid_o}, '0);
    tick();

    disp(3, 26'h0A0, 2); drain();
    look(5, 26'h0A0, 12'h5A5); drain();
    chk(last_status == 2'd1, "R5 append on hit", last_status, 2'd1);
    look(1, 26'h777, 12'h001); drain();
    chk(last_status == 2'd0, "R7 lookup miss", last_status, 2'd0);
    disp(2, 26'h0B0, 16); drain();
    look(2, 26'h0B0, 12'h123); drain();
    chk(last_status == 2'd2, "R6 no room", last_status, 2'd2);

    // fill and every bank on the same edge
    gnt_log = {};
    begin
      automatic int rm_before = rm_cnt;
      fill(26'h999);
      for (int b = 0; b < B; b++) look(b, 26'h0B0, W'(b));
      drain();
      chk(gnt_log[0] == 100, "R2 fill before banks", gnt_log[0], 100);
      for (int i = 1; i < B; i++)
        chk(gnt_log[i+1] - 50 == (gnt_log[i] - 50 + 1) % B, "R2 round robin order",
            gnt_log[i+1], 50 + (gnt_log[i] - 50 + 1) % B);
      chk(last_fill_hit == 0 && rm_cnt == rm_before, "R10 fill miss", {last_fill_hit, rm_cnt}, rm_before);
    end

    // displacement ahead of lookup within a bank
    gnt_log = {};
    disp(6, 26'h0C0, 1); look(6, 26'h0A0, 12'h111); drain();
    chk(gnt_log[0] == 6 && gnt_log[1] == 56, "R2 displacement first in bank", gnt_log[0], 6);

    fill(26'h0A0); drain();
    chk(last_fill_hit && last_fill_num == 4, "R4 returned count", last_fill_num, 4);
    chk(last_fill_subs[0] == subval(26'h0A0, 0) && last_fill_subs[1] == subval(26'h0A0, 1)
        && last_fill_subs[2] == 12'h5A5 && last_fill_subs[3] == 12'h111 && last_fill_subs[4] == '0,
        "R4 returned subentries", last_fill_subs, subval(26'h0A0, 0));
    chk(last_rm == 26'h0A0, "R9 remove address", last_rm, 26'h0A0);

    for (int i = 0; m_tab.num() < E; i++) begin
      disp(i % B, 26'h1000 + i, 1); drain();
    end
    chk(full_o === '1, "R8 full when all used", full_o, '1);
    disp(2, 26'h2000, 1); look(4, 26'h1000, 12'h0AA);
    repeat (10) tick();
    chk(disp_valid[2] == 1 && last_status == 2'd1, "R8 displacement held, lookup served",
        {disp_valid[2], last_status}, 3'b101);
    fill(26'h1001);
    repeat (8) tick();
    chk(disp_valid[2] == 0 && full_o === '1, "R8 held displacement granted after free",
        {disp_valid[2], full_o}, {1'b0, {B{1'b1}}});
    chk(last_rm == 26'h1001, "R9 remove after fill", last_rm, 26'h1001);
    drain();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule